// File: doc/BRIEF.md
# Progressive Sensor Readout Timing Generator

This block produces the self-timed readout schedule for a progressive colour image array of 660 by 492 active pixels. Running from the master clock, it divides that clock by two to make a data clock, steps a column counter once per data clock and a row counter once per line, and from those two counters derives the horizontal and vertical sync pulses and a per-pixel region code. The region code tells the downstream datapath whether the current pixel is optically shielded black reference, a shielded dummy, a true image pixel, or blanking.

Each line runs 30 black-reference pixels, 2 dummies, 660 image pixels, 2 more dummies and 88 blanking pixels. A full frame has 525 lines: 31 blanking lines, 2 shielded dummy lines and 492 image lines. A monitoring mode shortens the frame to 263 lines (17 blanking, 2 dummy, 244 image) and narrows the vertical pulse. The mode request is taken only when a frame ends. An active-high run input freezes the readout position while it is low. At a 24.54545 MHz master clock, normal mode gives 30 frames per second.

Top module: `sensor_sync_gen`

## Requirements
- R1: `dclk` is 0 in the first cycle after reset and inverts on every master clock edge. `pix_stb` is high only in cycles where `dclk` is 1 and `run` is 1. The column advances on the clock edge that ends each such cycle.
- R2: Reset (active-low `rst_n`) clears `col` and `row`, sets `dclk` to 0 and selects normal mode (`mon_act` = 0), whatever `mon_sel` is.
- R3: A line is OB_PIX+2*DUM_PIX+EFF_PIX+INV_PIX data clocks long and `col` wraps to 0 after its last value. The column classes in order are: black reference, dummy, effective, dummy, invalid.
- R4: In normal mode a frame has N_INV_LN invalid lines, then DUM_LN dummy lines, then N_EFF_LN effective lines. `row` wraps to 0 after the last line.
- R5: In monitoring mode a frame has M_INV_LN invalid lines, then DUM_LN dummy lines, then M_EFF_LN effective lines.
- R6: `region` encodes 00 invalid, 01 black reference, 10 dummy and 11 effective. On invalid lines every pixel is 00. On dummy lines invalid columns are 00 and all other columns are 10. On effective lines the code is the column class.
- R7: `hd` is 1 exactly while `col` < HD_W.
- R8: `vd` is 1 exactly while `row` < N_VD_W in normal mode, or `row` < M_VD_W in monitoring mode.
- R9: While `run` is 0, `col`, `row`, `region`, `hd` and `vd` hold their values and `pix_stb` is 0. `dclk` keeps toggling.
- R10: `mon_sel` is loaded into `mon_act` only on the advance that wraps both `col` and `row` to 0. A change of `mon_sel` mid-frame therefore does not alter the current frame's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = readout active, 0 = readout halted |
| mon_sel | input | 1 | Requested mode: 1 = monitoring, 0 = normal |
| dclk | output | 1 | Half-rate data clock |
| pix_stb | output | 1 | Pixel is valid this cycle |
| hd | output | 1 | Horizontal sync pulse |
| vd | output | 1 | Vertical sync pulse |
| region | output | 2 | Region code of the current pixel |
| col | output | CW | Column counter |
| row | output | RW | Row counter |
| mon_act | output | 1 | Mode in force for the current frame |

## Verification
At full size a normal frame is about 821,000 master cycles, so the bench builds the block scaled down. Each line has 3 black, 1 dummy, 6 effective, 1 dummy and 4 invalid pixels, with a 2-column HD. The normal frame has 3 invalid, 1 dummy and 6 effective lines with a 2-line VD. The monitoring frame has 2 invalid, 1 dummy and 3 effective lines with a 1-line VD. At these sizes the bench can run several complete frames in both modes. Every column and row boundary, every region transition, halts that land mid-line, and mode requests made mid-frame are each reached many times, all within a few thousand cycles.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic [1:0] {
    RGN_INVALID = 2'b00,
    RGN_OB      = 2'b01,
    RGN_DUMMY   = 2'b10,
    RGN_EFF     = 2'b11
  } rgn_e;

  // Column class within one line.
  function automatic rgn_e col_class(int c, int ob, int dum, int eff);
    if (c < ob)                    return RGN_OB;
    else if (c < ob + dum)         return RGN_DUMMY;
    else if (c < ob + dum + eff)   return RGN_EFF;
    else if (c < ob + 2*dum + eff) return RGN_DUMMY;
    else                           return RGN_INVALID;
  endfunction

  // Row kind: 0 invalid, 1 dummy, 2 effective.
  function automatic int row_kind(int r, int inv, int dum);
    if (r < inv)            return 0;
    else if (r < inv + dum) return 1;
    else                    return 2;
  endfunction

  function automatic rgn_e merge_region(int rk, rgn_e cc);
    if (rk == 0)      return RGN_INVALID;
    else if (rk == 1) return (cc == RGN_INVALID) ? RGN_INVALID : RGN_DUMMY;
    else              return cc;
  endfunction

endpackage

// File: rtl/sg_phase.sv
module sg_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ph,
  output logic adv
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end

  assign adv = ph & run;

  assert_dclk_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ph != $past(ph));
endmodule

// File: rtl/sg_hcount.sv
module sg_hcount #(
  parameter int LINE_LEN = 782,
  parameter int CW       = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [CW-1:0] col,
  output logic          line_end
);
  localparam logic [CW-1:0] COL_LAST = CW'(LINE_LEN - 1);

  assign line_end = adv && (col == COL_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        col <= '0;
    else if (line_end) col <= '0;
    else if (adv)      col <= col + 1'b1;
  end

  assert_col_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(col));
  assert_col_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> col == '0);
  always_comb if (rst_n) assert_col_range_R3: assert (int'(col) < LINE_LEN);
endmodule

// File: rtl/sg_vcount.sv
module sg_vcount #(
  parameter int N_LINES = 525,
  parameter int M_LINES = 263,
  parameter int RW      = $clog2(N_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic          mon_sel,
  output logic [RW-1:0] row,
  output logic          mode_q,
  output logic          frame_end
);
  localparam logic [RW-1:0] N_LAST = RW'(N_LINES - 1);
  localparam logic [RW-1:0] M_LAST = RW'(M_LINES - 1);

  logic [RW-1:0] row_last;
  assign row_last  = mode_q ? M_LAST : N_LAST;
  assign frame_end = line_end && (row == row_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row    <= '0;
      mode_q <= 1'b0;
    end else if (frame_end) begin
      row    <= '0;
      mode_q <= mon_sel;
    end else if (line_end) begin
      row    <= row + 1'b1;
    end
  end

  assert_mode_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(mode_q));
  assert_row_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(row));
  always_comb if (rst_n) assert_row_range_R4: assert (int'(row) < (mode_q ? M_LINES : N_LINES));
endmodule

// File: rtl/sensor_sync_gen.sv
module sensor_sync_gen #(
  parameter int OB_PIX   = 30,
  parameter int DUM_PIX  = 2,
  parameter int EFF_PIX  = 660,
  parameter int INV_PIX  = 88,
  parameter int HD_W     = 64,
  parameter int N_INV_LN = 31,
  parameter int M_INV_LN = 17,
  parameter int DUM_LN   = 2,
  parameter int N_EFF_LN = 492,
  parameter int M_EFF_LN = 244,
  parameter int N_VD_W   = 4,
  parameter int M_VD_W   = 3,
  localparam int LINE_LEN = OB_PIX + 2*DUM_PIX + EFF_PIX + INV_PIX,
  localparam int N_LINES  = N_INV_LN + DUM_LN + N_EFF_LN,
  localparam int M_LINES  = M_INV_LN + DUM_LN + M_EFF_LN,
  localparam int CW       = $clog2(LINE_LEN),
  localparam int RW       = $clog2(N_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          mon_sel,
  output logic          dclk,
  output logic          pix_stb,
  output logic          hd,
  output logic          vd,
  output logic [1:0]    region,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic          mon_act
);
  import sg_pkg::*;

  logic ph, adv, line_end, frame_end;
  rgn_e cls, rgn;

  sg_phase u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .ph(ph), .adv(adv)
  );

  sg_hcount #(.LINE_LEN(LINE_LEN), .CW(CW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .adv(adv), .col(col), .line_end(line_end)
  );

  sg_vcount #(.N_LINES(N_LINES), .M_LINES(M_LINES), .RW(RW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .mon_sel(mon_sel),
    .row(row), .mode_q(mon_act), .frame_end(frame_end)
  );

  int inv_ln, vd_w;
  always_comb begin
    inv_ln = mon_act ? M_INV_LN : N_INV_LN;
    vd_w   = mon_act ? M_VD_W : N_VD_W;
    cls    = col_class(int'(col), OB_PIX, DUM_PIX, EFF_PIX);
    rgn    = merge_region(row_kind(int'(row), inv_ln, DUM_LN), cls);
  end

  assign dclk    = ph;
  assign pix_stb = adv;
  assign hd      = int'(col) < HD_W;
  assign vd      = int'(row) < vd_w;
  assign region  = rgn;

  assert_stb_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_stb |-> dclk);
  assert_vd_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vd) |-> row == '0);
  assert_hd_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hd) |-> col == '0);
  assert_frame_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (row == '0) && (col == '0));
endmodule

// File: tb/tb_sensor_sync_gen.sv
module tb_sensor_sync_gen;
  localparam int OB = 3, DM = 1, EF = 6, IV = 4, HDW = 2;
  localparam int NINV = 3, MINV = 2, DLN = 1, NEFF = 6, MEFF = 3, NVD = 2, MVD = 1;
  localparam int CW = 4, RW = 4;
  localparam int LL = 15;
  // Column segment ends (exclusive) and class codes: 1 OB, 2 dummy, 3 eff, 0 invalid
  localparam int SEG_END [5] = '{3, 4, 10, 11, 15};
  localparam int SEG_CLS [5] = '{1, 2, 3, 2, 0};
  // Stimulus table: cycles, run, mon_sel
  localparam int NV = 8;
  localparam int V_LEN [NV] = '{400, 37, 250, 400, 23, 300, 5, 700};
  localparam bit V_RUN [NV] = '{1, 0, 1, 1, 0, 1, 0, 1};
  localparam bit V_MON [NV] = '{0, 0, 1, 1, 1, 0, 0, 0};

  logic clk = 0, rst_n = 0, run = 0, mon_sel = 0;
  logic dclk, pix_stb, hd, vd, mon_act;
  logic [1:0] region;
  logic [CW-1:0] col;
  logic [RW-1:0] row;

  int checks = 0, fails = 0;
  bit finished = 0;
  int m_ph, m_col, m_row, m_mode;

  always #2 clk = ~clk;

  sensor_sync_gen #(
    .OB_PIX(OB), .DUM_PIX(DM), .EFF_PIX(EF), .INV_PIX(IV), .HD_W(HDW),
    .N_INV_LN(NINV), .M_INV_LN(MINV), .DUM_LN(DLN), .N_EFF_LN(NEFF),
    .M_EFF_LN(MEFF), .N_VD_W(NVD), .M_VD_W(MVD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .mon_sel(mon_sel), .dclk(dclk),
    .pix_stb(pix_stb), .hd(hd), .vd(vd), .region(region), .col(col),
    .row(row), .mon_act(mon_act)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (col=%0d row=%0d)", req, act, exp, m_col, m_row);
    end
  endtask

  function automatic int exp_region(int c, int r, int md);
    int cls = 0, inv, lines_eff;
    for (int i = 4; i >= 0; i--) if (c < SEG_END[i]) cls = SEG_CLS[i];
    inv = md ? MINV : NINV;
    if (r < inv) return 0;
    if (r < inv + DLN) return (cls == 0) ? 0 : 2;
    lines_eff = md ? MEFF : NEFF;
    return (r < inv + DLN + lines_eff) ? cls : -1;
  endfunction

  task automatic compare_all();
    chk("R1 dclk", dclk, m_ph);
    chk("R1,R9 pix_stb", pix_stb, m_ph & run);
    chk("R3 col", col, m_col);
    chk("R4,R5 row", row, m_row);
    chk("R10 mon_act", mon_act, m_mode);
    chk("R6 region", region, exp_region(m_col, m_row, m_mode));
    chk("R7 hd", hd, (m_col < HDW) ? 1 : 0);
    chk("R8 vd", vd, (m_row < (m_mode ? MVD : NVD)) ? 1 : 0);
  endtask

  task automatic model_step();
    int last_row;
    if (m_ph == 1 && run) begin
      last_row = m_mode ? (MINV + DLN + MEFF - 1) : (NINV + DLN + NEFF - 1);
      if (m_col == LL - 1) begin
        m_col = 0;
        if (m_row == last_row) begin m_row = 0; m_mode = mon_sel; end
        else m_row = m_row + 1;
      end else m_col = m_col + 1;
    end
    m_ph = 1 - m_ph;
  endtask

  task automatic model_reset();
    m_ph = 0; m_col = 0; m_row = 0; m_mode = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seen_mon_end;
    model_reset();
    repeat (4) @(negedge clk);
    // R2: reset state, with mon_sel requesting monitoring
    mon_sel = 1;
    @(negedge clk);
    chk("R2 col", col, 0); chk("R2 row", row, 0);
    chk("R2 dclk", dclk, 0); chk("R2 mon_act", mon_act, 0);
    mon_sel = 0; run = 1; rst_n = 1;
    compare_all();
    model_step();

    // Table walk
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < V_LEN[v]; k++) begin
        @(negedge clk);
        compare_all();
        run = V_RUN[v]; mon_sel = V_MON[v];
        model_step();
      end
    end

    // Directed R9: halt mid-line, outputs frozen for many cycles
    @(negedge clk); compare_all(); run = 0; model_step();
    begin
      int c0, r0, g0;
      @(negedge clk); c0 = col; r0 = row; g0 = region;
      for (int k = 0; k < 20; k++) begin
        chk("R9 col held", col, c0); chk("R9 row held", row, r0);
        chk("R9 region held", region, g0); chk("R9 stb low", pix_stb, 0);
        chk("R1,R9 dclk toggles", dclk, m_ph);
        model_step();
        @(negedge clk);
      end
      compare_all(); run = 1; model_step();
    end

    // Directed R10/R5: request monitoring, count lines until mode flips
    seen_mon_end = 0;
    mon_sel = 1;
    for (int k = 0; k < 700; k++) begin
      @(negedge clk); compare_all(); model_step();
      if (mon_act) seen_mon_end = 1;
    end
    chk("R10 mode switched at boundary", seen_mon_end, 1);
    chk("R5 monitoring frame row bound", (m_row < MINV + DLN + MEFF) ? 1 : 0, 1);

    // Directed R2: reset in the middle of operation
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R2 col after mid reset", col, 0); chk("R2 row after mid reset", row, 0);
    chk("R2 mode after mid reset", mon_act, 0); chk("R2 dclk after mid reset", dclk, 0);
    chk("R8 vd at reset", vd, 1); chk("R7 hd at reset", hd, 1);
    chk("R6 region at reset", region, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule